// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block is the master side of a serial configuration link to a programmable device. When software or a boot sequencer pulses `start` with a byte count and a mode bit, the loader does four things in turn. It holds the device's active-low program input low for a programmable time. It waits, with a bounded poll, for the device to raise its ready line. It then serialises the bitstream bytes that arrive on a valid/ready byte stream, most significant bit first, one serial clock pulse per bit. Finally it keeps pulsing the serial clock until the device reports that it is configured, again within a bounded number of pulses.

In word-swap mode the loader collects four stream bytes and sends them last-first. Byte `i` of the image therefore goes out in position `i XOR 3`. This turns little-endian 32-bit words in memory into the big-end-first order the device expects. The result is given by three mutually exclusive status outputs: `busy`, `load_ok` and `load_err`. `load_ok` and `load_err` hold until the next accepted start.

The controller is one state machine. Its states are:

| State | Behaviour | Leaves to |
|---|---|---|
| IDLE, OK, FAIL | Rest states. | On `start`: FAIL for a bad length in word-swap mode, otherwise PROG. |
| PROG | Program pulse runs. | WAIT_INIT once the pulse time expires. |
| WAIT_INIT | Polls `dev_ready`. | If ready: FETCH, or FLUSH_LO when the length is zero. If the poll limit runs out: FAIL. |
| FETCH | Waits for a byte from the stream (or from the swap buffer). | BIT_LO once a byte is taken. |
| BIT_LO, BIT_HI | The two halves of each bit period. | After BIT_HI: BIT_LO for the next bit, FETCH for the next byte, or FLUSH_LO after the last byte. |
| FLUSH_LO | Samples `dev_configured`. | OK if it is high, otherwise FLUSH_HI. |
| FLUSH_HI | High half of a post-data pulse. | FLUSH_LO for another pulse, or FAIL once the pulse limit is spent. |

Top module: `cfg_serial_loader`

## Requirements
- R1: While not busy (after reset and in the rest states), `pgm_n`=1, `ser_clk`=0, `ser_data`=0 and `s_ready`=0. Out of reset, `busy`, `load_ok` and `load_err` are all 0.
- R2: An accepted `start` drives `pgm_n` low from the next cycle for exactly PROG_CYCLES cycles. No serial clock pulse and no stream byte is taken during that time.
- R3: After the pulse, `dev_ready` is polled once per cycle. If it is low on INIT_POLLS consecutive polls, the load ends with `load_err`=1, no clock pulse and no byte taken.
- R4: Each byte goes out bit 7 first and bit 0 last, with exactly one rising edge of `ser_clk` per bit. `ser_data` is already valid and unchanged at each rising edge.
- R5: Every high phase of `ser_clk` lasts exactly CLK_HALF cycles, and every low phase lasts at least CLK_HALF cycles.
- R6: After the last data bit, the loader samples `dev_configured` during each low phase and stops with `load_ok`=1 as soon as it is high, so zero extra pulses are given if it is already high. If it is still low after DONE_PULSES extra pulses, the load ends with `load_err`=1.
- R7: With `reverse`=1, image byte `i` (counted from 0 in stream order) is sent in position `i XOR 3`: stream order 0,1,2,3,4,5,6,7 goes out as 3,2,1,0,7,6,5,4.
- R8: At most one of `busy`, `load_ok` and `load_err` is 1. `load_ok` and `load_err` hold until an accepted `start` clears them in the following cycle, when `busy` becomes 1.
- R9: A `start` with `reverse`=1 and a length whose two low bits are not 00 (not a multiple of four) raises `load_err` in the next cycle. No program pulse is given and no byte is taken.
- R10: `start` is ignored while `busy`=1. The length and mode of the running load are kept.
- R11: Exactly `length` bytes are accepted from the stream per load (valid and ready both high at a clock edge). `s_ready` is never high outside the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse, taken only when not busy |
| length | input | LEN_W | Number of image bytes for this load |
| reverse | input | 1 | 1 = send each 4-byte group last byte first |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte is valid |
| s_ready | output | 1 | Loader accepts the stream byte this cycle |
| pgm_n | output | 1 | Active-low program pulse to the device |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| dev_ready | input | 1 | Device ready-for-data line (pulled up on the board) |
| dev_configured | input | 1 | Device configured line (pulled up on the board) |
| busy | output | 1 | A load is in progress |
| load_ok | output | 1 | Last load finished with the device configured |
| load_err | output | 1 | Last load was rejected or timed out |

## Verification
The assertions take for granted that `dev_ready`, `dev_configured`, `start` and the stream signals are synchronous to `clk`, with no metastability. They also take for granted that a stream byte stays unchanged while it is offered and not yet accepted. The bench keeps within this by driving every input on the falling clock edge. It holds each offered byte until the handshake, and models the device so that its lines move only in response to the program pulse and the counted serial clock edges.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    localparam int WORD_BYTES = 4;
    localparam int BYTE_BITS  = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_FLUSH_LO,
        ST_FLUSH_HI,
        ST_OK,
        ST_FAIL
    } ld_state_t;

endpackage

// File: rtl/cfg_span_counter.sv
module cfg_span_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/cfg_byte_feed.sv
module cfg_byte_feed #(
    parameter int WORD_BYTES = 4,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rev,
    input  logic          take_req,
    input  logic          take,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    output logic          s_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_byte
);

    localparam int IDX_W = $clog2(WORD_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);
    localparam logic [IDX_W:0]   FULL_CNT = (IDX_W + 1)'(WORD_BYTES);

    logic [DW-1:0]  buf_q [WORD_BYTES];
    logic [IDX_W:0] fill;
    logic [IDX_W-1:0] rd;
    logic           full;

    assign full = (fill == FULL_CNT);

    always_comb begin
        if (rev) begin
            s_ready   = take_req && !full;
            out_valid = full;
            out_byte  = buf_q[rd];
        end else begin
            s_ready   = take_req;
            out_valid = s_valid;
            out_byte  = s_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
            rd   <= LAST_IDX;
        end else if (clear) begin
            fill <= '0;
            rd   <= LAST_IDX;
        end else if (rev) begin
            if (s_valid && s_ready) begin
                fill <= fill + 1'b1;
            end else if (take) begin
                if (rd == '0) begin
                    fill <= '0;
                    rd   <= LAST_IDX;
                end else begin
                    rd <= rd - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rev && s_valid && s_ready) begin
            buf_q[fill[IDX_W-1:0]] <= s_data;
        end
    end

    // R11: the sequencer only takes a byte that is on offer
    assert_take_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> out_valid);

    // R7: a word stays on offer, and closed to the stream, until its last byte leaves
    assert_word_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rev && take && (rd != '0) && !clear |=> out_valid && !s_ready);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_load_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int PROG_CYCLES = 10_000_000,
    parameter int INIT_POLLS  = 100_000,
    parameter int DONE_PULSES = 100_000,
    parameter int CLK_HALF    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] length,
    input  logic             reverse,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             pgm_n,
    output logic             ser_clk,
    output logic             ser_data,
    input  logic             dev_ready,
    input  logic             dev_configured,
    output logic             busy,
    output logic             load_ok,
    output logic             load_err
);

    localparam int WB_W     = $clog2(WORD_BYTES);
    localparam int BIT_W    = $clog2(BYTE_BITS);
    localparam int PH_W     = $clog2(CLK_HALF + 1);
    localparam int WAIT_MAX = (PROG_CYCLES > INIT_POLLS)
        ? ((PROG_CYCLES > DONE_PULSES) ? PROG_CYCLES : DONE_PULSES)
        : ((INIT_POLLS  > DONE_PULSES) ? INIT_POLLS  : DONE_PULSES);
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

    localparam logic [WAIT_W-1:0] PROG_LD = WAIT_W'(PROG_CYCLES - 1);
    localparam logic [WAIT_W-1:0] INIT_LD = WAIT_W'(INIT_POLLS - 1);
    localparam logic [WAIT_W-1:0] DONE_LD = WAIT_W'(DONE_PULSES - 1);
    localparam logic [PH_W-1:0]   PH_LD   = PH_W'(CLK_HALF - 1);
    localparam logic [BIT_W-1:0]  BIT_LD  = BIT_W'(BYTE_BITS - 1);

    ld_state_t st, st_nx;

    logic                 ld_start, take;
    logic                 wt_load, wt_dec, wt_zero;
    logic [WAIT_W-1:0]    wt_val;
    logic                 ph_load, ph_zero;
    logic                 feed_valid;
    logic [BYTE_BITS-1:0] feed_byte;
    logic [LEN_W-1:0]     remain;
    logic                 rev_q;
    logic [BYTE_BITS-1:0] shreg;
    logic [BIT_W-1:0]     bits_left;

    cfg_span_counter #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .dec      (wt_dec),
        .zero     (wt_zero)
    );

    cfg_span_counter #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (PH_LD),
        .dec      (1'b1),
        .zero     (ph_zero)
    );

    cfg_byte_feed #(.WORD_BYTES(WORD_BYTES), .DW(BYTE_BITS)) u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ld_start),
        .rev       (rev_q),
        .take_req  (st == ST_FETCH),
        .take      (take),
        .s_data    (s_data),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .out_valid (feed_valid),
        .out_byte  (feed_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state and counter control
    always_comb begin
        st_nx    = st;
        ld_start = 1'b0;
        take     = 1'b0;
        wt_load  = 1'b0;
        wt_val   = '0;
        wt_dec   = 1'b0;
        ph_load  = 1'b0;
        unique case (st)
            ST_IDLE, ST_OK, ST_FAIL: begin
                if (start) begin
                    ld_start = 1'b1;
                    if (reverse && (length[WB_W-1:0] != '0)) begin
                        st_nx = ST_FAIL;
                    end else begin
                        st_nx   = ST_PROG;
                        wt_load = 1'b1;
                        wt_val  = PROG_LD;
                    end
                end
            end
            ST_PROG: begin
                if (wt_zero) begin
                    st_nx   = ST_WAIT_INIT;
                    wt_load = 1'b1;
                    wt_val  = INIT_LD;
                end else begin
                    wt_dec = 1'b1;
                end
            end
            ST_WAIT_INIT: begin
                if (dev_ready) begin
                    ph_load = 1'b1;
                    if (remain == '0) begin
                        st_nx   = ST_FLUSH_LO;
                        wt_load = 1'b1;
                        wt_val  = DONE_LD;
                    end else begin
                        st_nx = ST_FETCH;
                    end
                end else if (wt_zero) begin
                    st_nx = ST_FAIL;
                end else begin
                    wt_dec = 1'b1;
                end
            end
            ST_FETCH: begin
                if (feed_valid) begin
                    take    = 1'b1;
                    ph_load = 1'b1;
                    st_nx   = ST_BIT_LO;
                end
            end
            ST_BIT_LO: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    st_nx   = ST_BIT_HI;
                end
            end
            ST_BIT_HI: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    if (bits_left != '0) begin
                        st_nx = ST_BIT_LO;
                    end else if (remain == LEN_W'(1)) begin
                        st_nx   = ST_FLUSH_LO;
                        wt_load = 1'b1;
                        wt_val  = DONE_LD;
                    end else begin
                        st_nx = ST_FETCH;
                    end
                end
            end
            ST_FLUSH_LO: begin
                if (dev_configured) begin
                    st_nx = ST_OK;
                end else if (ph_zero) begin
                    ph_load = 1'b1;
                    st_nx   = ST_FLUSH_HI;
                end
            end
            ST_FLUSH_HI: begin
                if (ph_zero) begin
                    if (wt_zero) begin
                        st_nx = ST_FAIL;
                    end else begin
                        wt_dec  = 1'b1;
                        ph_load = 1'b1;
                        st_nx   = ST_FLUSH_LO;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Byte and bit bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain    <= '0;
            rev_q     <= 1'b0;
            shreg     <= '0;
            bits_left <= '0;
        end else begin
            if (ld_start) begin
                remain <= length;
                rev_q  <= reverse;
            end
            if (take) begin
                shreg     <= feed_byte;
                bits_left <= BIT_LD;
            end else if (st == ST_BIT_HI && ph_zero) begin
                if (bits_left != '0) begin
                    shreg     <= shreg << 1;
                    bits_left <= bits_left - 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        pgm_n    = (st != ST_PROG);
        ser_clk  = (st == ST_BIT_HI) || (st == ST_FLUSH_HI);
        ser_data = ((st == ST_BIT_LO) || (st == ST_BIT_HI)) && shreg[BYTE_BITS-1];
        busy     = !((st == ST_IDLE) || (st == ST_OK) || (st == ST_FAIL));
        load_ok  = (st == ST_OK);
        load_err = (st == ST_FAIL);
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pgm_n && !ser_clk && !ser_data);

    assert_pulse_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_n |-> busy && !ser_clk && !s_ready);

    assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    assert_status_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, load_ok, load_err}));

    assert_ok_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok && !start |=> load_ok);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_err && !start |=> load_err);

    assert_reject_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && reverse && (length[WB_W-1:0] != '0) |=> load_err && pgm_n);

    assert_ready_in_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> busy && pgm_n && !ser_clk);

endmodule

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;

    localparam int LEN_W       = 16;
    localparam int PROG_CYCLES = 20;
    localparam int INIT_POLLS  = 40;
    localparam int DONE_PULSES = 25;
    localparam int CLK_HALF    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] length = '0;
    logic             reverse = 1'b0;
    logic [7:0]       s_data = '0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic             pgm_n, ser_clk, ser_data;
    logic             dev_ready = 1'b0;
    logic             dev_configured = 1'b0;
    logic             busy, load_ok, load_err;

    cfg_serial_loader #(
        .LEN_W(LEN_W), .PROG_CYCLES(PROG_CYCLES), .INIT_POLLS(INIT_POLLS),
        .DONE_PULSES(DONE_PULSES), .CLK_HALF(CLK_HALF)
    ) i_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .length(length), .reverse(reverse),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .pgm_n(pgm_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .dev_ready(dev_ready), .dev_configured(dev_configured),
        .busy(busy), .load_ok(load_ok), .load_err(load_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0] src_q[$];
    bit         cap_q[$];
    int  src_idx = 0;
    int  rises = 0;
    int  prog_low_cnt = 0;
    int  wait_cnt = 0;
    int  init_delay = -1;
    int  init_cnt = 0;
    int  done_at = -1;
    int  hi_run = 0;
    bit  prev_clk = 0;
    bit  feed_stop = 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // device model and per-clock comparison, sampled on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!pgm_n) begin
                    prog_low_cnt++;
                    init_cnt = 0;
                    dev_ready = 1'b0;
                    dev_configured = 1'b0;
                    rises = 0;
                end else if (init_delay >= 0) begin
                    if (init_cnt >= init_delay) dev_ready = 1'b1;
                    init_cnt++;
                end
                if (busy && pgm_n && rises == 0 && !dev_ready) wait_cnt++;
                if (ser_clk && !prev_clk) begin
                    cap_q.push_back(ser_data);
                    rises++;
                end
                if (ser_clk) begin
                    hi_run++;
                end else if (prev_clk) begin
                    check(hi_run == CLK_HALF, "R5", "clock high phase length", hi_run, CLK_HALF);
                    hi_run = 0;
                end
                if (pgm_n && done_at >= 0 && rises >= done_at) dev_configured = 1'b1;
                if (!busy) begin
                    check(pgm_n && !ser_clk && !ser_data && !s_ready, "R1",
                          "rest levels {pgm_n,clk,data,ready}",
                          {pgm_n, ser_clk, ser_data, s_ready}, 4'b1000);
                end
                prev_clk = ser_clk;
            end
        end
    end

    task automatic feeder(input bit gaps);
        int cyc = 0;
        while (!feed_stop) begin
            bit hs;
            @(negedge clk);
            cyc++;
            if (src_idx < src_q.size() && !(gaps && (cyc % 3 == 1))) begin
                s_valid = 1'b1;
                s_data  = src_q[src_idx];
            end else begin
                s_valid = 1'b0;
            end
            #1;
            hs = s_valid && s_ready;
            @(posedge clk);
            if (hs) src_idx++;
        end
        s_valid = 1'b0;
    endtask

    // extra < 0: device never configures; idelay < 0: device never ready
    task automatic run_case(input int len, input bit rev, input int idelay,
                            input int extra, input int glitch_at, input bit gaps);
        int n;
        int exp_extra;
        int bad;
        bit exp_ok;
        cap_q.delete();
        rises = 0; prog_low_cnt = 0; wait_cnt = 0; src_idx = 0; hi_run = 0;
        init_delay = idelay;
        done_at = (extra >= 0) ? (8 * len + extra) : -1;
        feed_stop = 0;
        @(negedge clk);
        length = LEN_W'(len); reverse = rev; start = 1'b1;
        fork feeder(gaps); join_none
        @(negedge clk);
        start = 1'b0;
        check(busy && !load_ok && !load_err, "R8", "start clears status {busy,ok,err}",
              {busy, load_ok, load_err}, 3'b100);
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
            if (n == glitch_at) begin
                start = 1'b1; length = 3; reverse = !rev;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        feed_stop = 1;
        repeat (3) @(negedge clk);
        check(prog_low_cnt == PROG_CYCLES, "R2", "program pulse cycles", prog_low_cnt, PROG_CYCLES);
        if (idelay < 0) begin
            check(load_err && !load_ok, "R3", "ready timeout flags error", load_err, 1);
            check(wait_cnt == INIT_POLLS, "R3", "ready polls before abort", wait_cnt, INIT_POLLS);
            check(rises == 0 && src_idx == 0, "R3", "clock pulses and bytes after timeout",
                  rises + src_idx, 0);
        end else begin
            exp_ok = (extra >= 0);
            exp_extra = (extra >= 0) ? extra : DONE_PULSES;
            check(load_ok == exp_ok && load_err == !exp_ok, "R6", "final status ok", load_ok, exp_ok);
            check(rises - 8 * len == exp_extra, "R6", "post-data pulses", rises - 8 * len, exp_extra);
            check(src_idx == len, "R11", "bytes accepted", src_idx, len);
            bad = -1;
            for (int i = 0; i < 8 * len; i++) begin
                int j;
                int k;
                j = rev ? ((i / 8) ^ 3) : (i / 8);
                k = 7 - (i % 8);
                if (bad < 0 && (i >= cap_q.size() || cap_q[i] != src_q[j][k])) bad = i;
            end
            check(bad < 0, rev ? "R7" : "R4", "first wrong serial bit index", bad, -1);
            if (glitch_at > 0) check(src_idx == len, "R10", "start while busy changed length", src_idx, len);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pgm_n && !ser_clk && !ser_data && !s_ready && !busy && !load_ok && !load_err,
              "R1", "reset outputs", {pgm_n, ser_clk, ser_data, s_ready, busy, load_ok, load_err},
              7'b1000000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        src_q = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hF0, 8'h77, 8'h66};
        run_case(5, 1'b0, 6, 3, 0, 1'b1);

        src_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
        run_case(8, 1'b1, 0, 0, 0, 1'b0);

        repeat (10) @(negedge clk);
        check(load_ok && !busy, "R8", "ok held while idle", load_ok, 1);

        // R9: word-swap with a length that is not a multiple of four
        src_q = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
        prog_low_cnt = 0; src_idx = 0; rises = 0;
        @(negedge clk);
        length = 6; reverse = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(load_err && !busy && !load_ok, "R9", "bad length rejected", load_err, 1);
        repeat (5) @(negedge clk);
        check(prog_low_cnt == 0 && rises == 0, "R9", "no pulse after reject", prog_low_cnt + rises, 0);

        src_q = '{8'hDE, 8'hAD};
        run_case(2, 1'b0, -1, 0, 0, 1'b0);

        src_q = '{8'hC3, 8'h00};
        run_case(1, 1'b0, 2, -1, 0, 1'b0);

        src_q = '{8'h0F, 8'hE1, 8'h5A, 8'h96, 8'h42};
        run_case(4, 1'b1, 3, 1, 0, 1'b1);

        src_q = '{8'hFF};
        run_case(0, 1'b0, 1, 2, 0, 1'b0);

        src_q = '{8'h81, 8'h7E, 8'hC5, 8'h3A};
        run_case(3, 1'b0, 2, 1, 40, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule